// File: doc/BRIEF.md
# Interrupt Controller Programming Port

This block is the byte-wide, two-address programming port of an eight-line priority interrupt controller. A processor writes initialization bytes and operation commands through it. The block keeps the line mask, the in-service register, the vector base, the mode flags and the rotating priority offset. It compares the pending request vector, which a separate capture stage supplies, against that state. It raises `int_o` when a request outranks everything in service. It answers processor acknowledges with a vector, and register reads and poll reads with a data byte.

Priority rotates. The rank of line L is (L - offset) mod 8, and rank 0 wins. Commands clear in-service bits, either the top-ranked bit or a named bit. Some commands also move the offset so that the serviced line becomes the lowest priority. In auto-clear mode an acknowledge does not set the in-service bit, and it can rotate the offset on its own.

The port has no back-pressure. One access is taken per cycle, and both ready conditions are always true. When strobes collide in one cycle, a write takes precedence over a read, and a read over an acknowledge. The lower-priority strobe is dropped. Each response (`rd_vld`, `ack_vld`, `req_clr`) is a one-cycle pulse in the cycle after its strobe.

Top module: `pic_cmd_port`

## Requirements
- R1: After reset the mask, in-service register, offset and every mode flag are zero, and the register select picks the request vector. A read of address 1 returns 0x00, and a read of address 0 returns `irq_req`.
- R2: A write to address 0 with bit 4 set starts initialization. It clears the mask, in-service register, offset, mode flags and armed poll. The following address-1 bytes are taken in order: base; then the cascade byte, unless bit 1 of the first byte was set; then the mode byte, if bit 0 of the first byte was set. Those bytes do not load the mask.
- R3: The base byte stores data AND 0xF8. In the mode byte, bit 4 enables special nesting and bit 1 enables auto-clear.
- R4: In normal mode, an address-1 write loads the mask and an address-1 read returns it. Masked lines never raise `int_o` and are never acknowledged.
- R5: An address-0 write with bit 4 = 0 and bit 3 = 1 is a read-control command. Bit 0 selects what a read of address 0 returns (1 = in-service, 0 = request), bit 5 sets special mask mode, and bit 2 arms a poll.
- R6: When a poll is armed, the next read of either address returns 0x80 | line if an interrupt would be raised. That read pulses `req_clr` for the line and clears the line's in-service bit. Otherwise the read returns 0x00. The read disarms the poll.
- R7: `int_o` is high exactly when the best-ranked unmasked request outranks the best-ranked counted in-service bit, or when no in-service bit is counted.
- R8: An acknowledge when `int_o` would be high returns base | line on `ack_vec`, pulses `req_clr` for that line, and sets its in-service bit. An acknowledge with nothing pending returns base | 7 and changes nothing.
- R9: With auto-clear on, an acknowledge leaves the in-service register unchanged. If rotate-on-auto-clear is also on, the offset becomes (line + 1) mod 8.
- R10: Operation command code = data[7:5] on an address-0 write with bits 4 and 3 clear. Code 1 clears the top-ranked in-service bit. Code 5 does the same and then sets the offset to (line + 1) mod 8. Neither has any effect when nothing is in service.
- R11: Code 3 clears the in-service bit named by data[2:0]. Code 7 clears it and sets the offset to (data[2:0] + 1) mod 8.
- R12: Code 6 sets the offset to (data[2:0] + 1) mod 8. Code 2 has no effect. Codes 0 and 4 load rotate-on-auto-clear from data[7].
- R13: With special nesting on, the in-service bit of the cascade line (`CASC_LINE`, default 2) is not counted in R7. With special mask on, in-service bits of masked lines are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 1 | Write address bit |
| wr_data | input | 8 | Write data byte |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 1 | Read address bit |
| rd_data | output | 8 | Read result, valid with rd_vld |
| rd_vld | output | 1 | Read result pulse |
| ack_i | input | 1 | Processor acknowledge strobe |
| ack_vld | output | 1 | Acknowledge result pulse |
| ack_vec | output | 8 | Vector returned on acknowledge |
| irq_req | input | NLINES | Pending request vector from the capture stage |
| req_clr | output | NLINES | One-hot pulse telling the capture stage to drop a request |
| int_o | output | 1 | Interrupt request to the processor |

## Verification
The bench goes after the places where rank and line numbers separate.

- A nonzero offset must rank lines by (line - offset) mod 8. A design that used raw line numbers would acknowledge the wrong line after a rotate command.
- Nested service must hold lower requests back until an end-of-service command. A design that compared line numbers instead of ranks would drop `int_o` too early or too late.
- A poll read with nothing pending must return 0x00 and change no state.
- An init sequence that skips the cascade byte must return to normal mode one byte earlier. Otherwise the next mask write would be swallowed as a mode byte.
- Auto-clear with rotation must leave the in-service register untouched while moving the offset.

// File: rtl/pic_port_pkg.sv
`timescale 1ns/1ps
package pic_port_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_BASE = 2'd1,
    SEQ_CASC = 2'd2,
    SEQ_MODE = 2'd3
  } seq_t;

  typedef struct packed {
    logic aeoi;    // acknowledge does not set in-service
    logic raeoi;   // rotate offset on auto-clear acknowledge
    logic sfnm;    // cascade line in-service not counted
    logic smm;     // masked in-service bits not counted
    logic rsel;    // 1: address-0 read returns in-service
  } mode_t;

  localparam logic [2:0] OP_RAE_CLR = 3'd0;
  localparam logic [2:0] OP_NS_EOI  = 3'd1;
  localparam logic [2:0] OP_NOP     = 3'd2;
  localparam logic [2:0] OP_SP_EOI  = 3'd3;
  localparam logic [2:0] OP_RAE_SET = 3'd4;
  localparam logic [2:0] OP_NS_ROT  = 3'd5;
  localparam logic [2:0] OP_SET_PRI = 3'd6;
  localparam logic [2:0] OP_SP_ROT  = 3'd7;

endpackage

// File: rtl/pic_prio_pick.sv
`timescale 1ns/1ps
// Rotating priority search: rank of line L is (L - off) mod NLINES.
// rank_o = NLINES when vec_i is empty. NLINES must be a power of two.
module pic_prio_pick #(
  parameter int NLINES = 8,
  localparam int LW = $clog2(NLINES)
) (
  input  logic [NLINES-1:0] vec_i,
  input  logic [LW-1:0]     off_i,
  output logic [LW:0]       rank_o
);
  logic [NLINES-1:0] rot;

  for (genvar g = 0; g < NLINES; g++) begin : g_rot
    logic [LW-1:0] idx;
    assign idx    = LW'(g) + off_i;
    assign rot[g] = vec_i[idx];
  end

  always_comb begin
    rank_o = (LW+1)'(NLINES);
    for (int i = NLINES-1; i >= 0; i--) begin
      if (rot[i]) rank_o = (LW+1)'(i);
    end
  end
endmodule

// File: rtl/pic_init_seq.sv
`timescale 1ns/1ps
// Tracks which address-1 byte of the initialization sequence comes next.
module pic_init_seq
  import pic_port_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic single_i,
  input  logic need4_i,
  input  logic byte_i,
  output logic busy_o,
  output logic base_take_o,
  output logic mode_take_o
);
  seq_t st_q;
  logic single_q, need4_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= SEQ_IDLE;
      single_q <= 1'b0;
      need4_q  <= 1'b0;
    end else if (start_i) begin
      st_q     <= SEQ_BASE;
      single_q <= single_i;
      need4_q  <= need4_i;
    end else if (byte_i) begin
      case (st_q)
        SEQ_BASE: st_q <= !single_q ? SEQ_CASC : (need4_q ? SEQ_MODE : SEQ_IDLE);
        SEQ_CASC: st_q <= need4_q ? SEQ_MODE : SEQ_IDLE;
        SEQ_MODE: st_q <= SEQ_IDLE;
        default:  st_q <= st_q;
      endcase
    end
  end

  assign busy_o      = (st_q != SEQ_IDLE);
  assign base_take_o = byte_i && (st_q == SEQ_BASE);
  assign mode_take_o = byte_i && (st_q == SEQ_MODE);
endmodule

// File: rtl/pic_cmd_port.sv
`timescale 1ns/1ps
module pic_cmd_port
  import pic_port_pkg::*;
#(
  parameter int NLINES    = 8,
  parameter int DW        = 8,
  parameter int CASC_LINE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_en,
  input  logic              rd_addr,
  output logic [DW-1:0]     rd_data,
  output logic              rd_vld,
  input  logic              ack_i,
  output logic              ack_vld,
  output logic [DW-1:0]     ack_vec,
  input  logic [NLINES-1:0] irq_req,
  output logic [NLINES-1:0] req_clr,
  output logic              int_o
);
  localparam int LW = $clog2(NLINES);
  localparam logic [DW-1:0] BASE_MASK = ~DW'(NLINES-1);
  localparam logic [NLINES-1:0] CASC_BIT = NLINES'(1) << CASC_LINE;
  localparam logic [LW-1:0] ONE = LW'(1);

  // state
  logic [NLINES-1:0] imr_q, imr_d, isr_q, isr_d;
  logic [LW-1:0]     off_q, off_d;
  logic [DW-1:0]     base_q, base_d;
  mode_t             mode_q, mode_d;
  logic              poll_q, poll_d;
  logic [DW-1:0]     rdd_q, rdd_d, akd_q, akd_d;
  logic              rdv_q, rdv_d, akv_q, akv_d;
  logic [NLINES-1:0] clr_q, clr_d;

  // decode
  logic start_w, rdctl_w, opcmd_w, a1_w, rd_go, ack_go;
  logic [2:0] code;
  logic [LW-1:0] named_line;
  assign start_w = wr_en && !wr_addr && wr_data[4];
  assign rdctl_w = wr_en && !wr_addr && !wr_data[4] && wr_data[3];
  assign opcmd_w = wr_en && !wr_addr && !wr_data[4] && !wr_data[3];
  assign a1_w    = wr_en && wr_addr;
  assign rd_go   = rd_en && !wr_en;
  assign ack_go  = ack_i && !wr_en && !rd_en;
  assign code    = wr_data[7:5];
  assign named_line = wr_data[LW-1:0];

  // init sequence
  logic seq_busy, base_take, mode_take;
  pic_init_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_w),
    .single_i    (wr_data[1]),
    .need4_i     (wr_data[0]),
    .byte_i      (a1_w),
    .busy_o      (seq_busy),
    .base_take_o (base_take),
    .mode_take_o (mode_take)
  );

  // priority lookups
  logic [NLINES-1:0] req_vec, cur_vec;
  logic [LW:0]       req_rank, cur_rank, isr_rank;
  logic [LW-1:0]     req_line, isr_line;
  logic              win, isr_hit;

  assign req_vec = irq_req & ~imr_q;
  assign cur_vec = isr_q & ~(mode_q.smm ? imr_q : '0) & ~(mode_q.sfnm ? CASC_BIT : '0);

  pic_prio_pick #(.NLINES(NLINES)) u_req_pick (
    .vec_i (req_vec), .off_i (off_q), .rank_o (req_rank));
  pic_prio_pick #(.NLINES(NLINES)) u_cur_pick (
    .vec_i (cur_vec), .off_i (off_q), .rank_o (cur_rank));
  pic_prio_pick #(.NLINES(NLINES)) u_isr_pick (
    .vec_i (isr_q),   .off_i (off_q), .rank_o (isr_rank));

  assign req_line = req_rank[LW-1:0] + off_q;
  assign isr_line = isr_rank[LW-1:0] + off_q;
  assign isr_hit  = !isr_rank[LW];
  assign win      = !req_rank[LW] && (req_rank < cur_rank);

  always_comb begin
    imr_d  = imr_q;
    isr_d  = isr_q;
    off_d  = off_q;
    base_d = base_q;
    mode_d = mode_q;
    poll_d = poll_q;
    rdd_d  = rdd_q;
    akd_d  = akd_q;
    rdv_d  = 1'b0;
    akv_d  = 1'b0;
    clr_d  = '0;
    if (start_w) begin
      imr_d  = '0;
      isr_d  = '0;
      off_d  = '0;
      mode_d = '0;
      poll_d = 1'b0;
    end else if (rdctl_w) begin
      mode_d.rsel = wr_data[0];
      mode_d.smm  = wr_data[5];
      poll_d      = wr_data[2];
    end else if (opcmd_w) begin
      case (code)
        OP_NS_EOI, OP_NS_ROT: begin
          if (isr_hit) begin
            isr_d[isr_line] = 1'b0;
            if (code == OP_NS_ROT) off_d = isr_line + ONE;
          end
        end
        OP_SP_EOI, OP_SP_ROT: begin
          isr_d[named_line] = 1'b0;
          if (code == OP_SP_ROT) off_d = named_line + ONE;
        end
        OP_SET_PRI:             off_d = named_line + ONE;
        OP_RAE_CLR, OP_RAE_SET: mode_d.raeoi = wr_data[7];
        default: ;
      endcase
    end else if (a1_w) begin
      if (base_take) begin
        base_d = wr_data & BASE_MASK;
      end else if (mode_take) begin
        mode_d.sfnm = wr_data[4];
        mode_d.aeoi = wr_data[1];
      end else if (!seq_busy) begin
        imr_d = wr_data[NLINES-1:0];
      end
    end else if (rd_go) begin
      rdv_d = 1'b1;
      if (poll_q) begin
        poll_d = 1'b0;
        if (win) begin
          rdd_d = {1'b1, (DW-1)'(req_line)};
          clr_d[req_line] = 1'b1;
          isr_d[req_line] = 1'b0;
        end else begin
          rdd_d = '0;
        end
      end else if (rd_addr) begin
        rdd_d = DW'(imr_q);
      end else begin
        rdd_d = mode_q.rsel ? DW'(isr_q) : DW'(irq_req);
      end
    end else if (ack_go) begin
      akv_d = 1'b1;
      if (win) begin
        akd_d = base_q | DW'(req_line);
        clr_d[req_line] = 1'b1;
        if (!mode_q.aeoi)      isr_d[req_line] = 1'b1;
        else if (mode_q.raeoi) off_d = req_line + ONE;
      end else begin
        akd_d = base_q | DW'(NLINES-1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      imr_q  <= '0;
      isr_q  <= '0;
      off_q  <= '0;
      base_q <= '0;
      mode_q <= '0;
      poll_q <= 1'b0;
      rdd_q  <= '0;
      akd_q  <= '0;
      rdv_q  <= 1'b0;
      akv_q  <= 1'b0;
      clr_q  <= '0;
    end else begin
      imr_q  <= imr_d;
      isr_q  <= isr_d;
      off_q  <= off_d;
      base_q <= base_d;
      mode_q <= mode_d;
      poll_q <= poll_d;
      rdd_q  <= rdd_d;
      akd_q  <= akd_d;
      rdv_q  <= rdv_d;
      akv_q  <= akv_d;
      clr_q  <= clr_d;
    end
  end

  assign rd_data = rdd_q;
  assign rd_vld  = rdv_q;
  assign ack_vec = akd_q;
  assign ack_vld = akv_q;
  assign req_clr = clr_q;
  assign int_o   = win;
endmodule

// File: rtl/pic_cmd_port_chk.sv
`timescale 1ns/1ps
module pic_cmd_port_chk #(
  parameter int NLINES = 8,
  parameter int DW     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              wr_addr,
  input logic [DW-1:0]     wr_data,
  input logic              rd_en,
  input logic              rd_addr,
  input logic [DW-1:0]     rd_data,
  input logic              rd_vld,
  input logic              ack_i,
  input logic              ack_vld,
  input logic [NLINES-1:0] irq_req,
  input logic [NLINES-1:0] req_clr,
  input logic              int_o,
  input logic [NLINES-1:0] imr,
  input logic [NLINES-1:0] isr,
  input logic              aeoi,
  input logic              poll
);
  // R8
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !wr_en && !rd_en) |=> ack_vld);
  // R6
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en) |=> rd_vld);
  // R8
  clr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_clr));
  // R7
  int_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> (|(irq_req & ~imr)));
  // R2
  init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_addr && wr_data[4]) |=> (imr == '0 && isr == '0));
  // R9
  aeoi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !wr_en && !rd_en && aeoi) |=> $stable(isr));
  // R4
  mask_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && rd_addr && !poll) |=> (rd_data == DW'($past(imr))));
endmodule

bind pic_cmd_port pic_cmd_port_chk #(.NLINES(NLINES), .DW(DW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .rd_en   (rd_en),
  .rd_addr (rd_addr),
  .rd_data (rd_data),
  .rd_vld  (rd_vld),
  .ack_i   (ack_i),
  .ack_vld (ack_vld),
  .irq_req (irq_req),
  .req_clr (req_clr),
  .int_o   (int_o),
  .imr     (imr_q),
  .isr     (isr_q),
  .aeoi    (mode_q.aeoi),
  .poll    (poll_q)
);

// File: tb/pic_cmd_port_tb.sv
`timescale 1ns/1ps
module pic_cmd_port_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_addr = 1'b0, rd_en = 1'b0, rd_addr = 1'b0, ack_i = 1'b0;
  logic [7:0] wr_data = '0, req = '0;
  logic [7:0] rd_data, ack_vec, req_clr;
  logic       rd_vld, ack_vld, int_o;

  pic_cmd_port u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_vld(rd_vld),
    .ack_i(ack_i), .ack_vld(ack_vld), .ack_vec(ack_vec),
    .irq_req(req), .req_clr(req_clr), .int_o(int_o));

  // reference model state
  int m_imr = 0, m_isr = 0, m_off = 0, m_base = 0, m_seq = 0, m_single = 0, m_need4 = 0;
  int m_aeoi = 0, m_raeoi = 0, m_sfnm = 0, m_smm = 0, m_rsel = 0, m_poll = 0;
  int e_rdv = 0, e_rdd = 0, e_akv = 0, e_akd = 0, e_clr = 0;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string tag = "R1";

  function automatic int top_line(int v);
    for (int i = 0; i < 8; i++) begin
      int l = (i + m_off) % 8;
      if (v[l]) return l;
    end
    return -1;
  endfunction

  function automatic int cur_rank();
    int v = m_isr;
    if (m_smm != 0) v = v & ~m_imr;
    if (m_sfnm != 0) v = v & ~(1 << 2);
    for (int i = 0; i < 8; i++) if (v[(i + m_off) % 8]) return i;
    return 8;
  endfunction

  function automatic bit model_int();
    int w = top_line(int'(req) & ~m_imr);
    return (w >= 0) && (((w - m_off + 8) % 8) < cur_rank());
  endfunction

  task automatic model_step();
    logic [7:0] d;
    int l;
    e_rdv = 0; e_akv = 0; e_clr = 0;
    d = wr_data;
    if (wr_en) begin
      if (!wr_addr && d[4]) begin
        m_imr = 0; m_isr = 0; m_off = 0; m_aeoi = 0; m_raeoi = 0; m_sfnm = 0;
        m_smm = 0; m_rsel = 0; m_poll = 0; m_single = d[1]; m_need4 = d[0]; m_seq = 1;
      end else if (!wr_addr && d[3]) begin
        m_rsel = d[0]; m_smm = d[5]; m_poll = d[2];
      end else if (!wr_addr) begin
        case (int'(d[7:5]))
          1, 5: begin
            l = top_line(m_isr);
            if (l >= 0) begin
              m_isr = m_isr & ~(1 << l);
              if (d[7:5] == 3'd5) m_off = (l + 1) % 8;
            end
          end
          3, 7: begin
            m_isr = m_isr & ~(1 << d[2:0]);
            if (d[7:5] == 3'd7) m_off = (int'(d[2:0]) + 1) % 8;
          end
          6: m_off = (int'(d[2:0]) + 1) % 8;
          0, 4: m_raeoi = d[7];
          default: ;
        endcase
      end else begin
        case (m_seq)
          0: m_imr = d;
          1: begin m_base = d & 8'hF8; m_seq = (m_single == 0) ? 2 : (m_need4 != 0 ? 3 : 0); end
          2: m_seq = (m_need4 != 0) ? 3 : 0;
          default: begin m_sfnm = d[4]; m_aeoi = d[1]; m_seq = 0; end
        endcase
      end
    end else if (rd_en) begin
      e_rdv = 1;
      if (m_poll != 0) begin
        m_poll = 0;
        if (model_int()) begin
          l = top_line(int'(req) & ~m_imr);
          e_rdd = 'h80 | l; e_clr = 1 << l; m_isr = m_isr & ~(1 << l);
        end else e_rdd = 0;
      end else if (rd_addr) e_rdd = m_imr;
      else e_rdd = (m_rsel != 0) ? m_isr : int'(req);
    end else if (ack_i) begin
      e_akv = 1;
      if (model_int()) begin
        l = top_line(int'(req) & ~m_imr);
        e_akd = m_base | l; e_clr = 1 << l;
        if (m_aeoi == 0) m_isr = m_isr | (1 << l);
        else if (m_raeoi != 0) m_off = (l + 1) % 8;
      end else e_akd = m_base | 7;
    end
  endtask

  task automatic check(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    check("int_o", int'(int_o), int'(model_int()));
    check("rd_vld", int'(rd_vld), e_rdv);
    if (e_rdv != 0) check("rd_data", int'(rd_data), e_rdd);
    check("ack_vld", int'(ack_vld), e_akv);
    if (e_akv != 0) check("ack_vec", int'(ack_vec), e_akd);
    check("req_clr", int'(req_clr), e_clr);
  endtask

  task automatic cycle();
    @(posedge clk);
    model_step();
    @(negedge clk);
    wr_en = 0; rd_en = 0; ack_i = 0;
    compare();
    req = req & ~8'(e_clr);
  endtask

  task automatic wr(bit a, logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d; cycle();
  endtask
  task automatic rd(bit a);
    rd_en = 1; rd_addr = a; cycle();
  endtask
  task automatic ack();
    ack_i = 1; cycle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    tag = "R1"; req = 8'h24;
    rd(1); check("reset mask read", int'(rd_data), 0);
    rd(0); check("reset request read", int'(rd_data), 'h24);
    cycle();
    req = 8'h00;
    // R2 / R3: full init with cascade and mode bytes
    tag = "R2"; wr(0, 8'h11); wr(1, 8'h47);
    tag = "R3"; wr(1, 8'h04); wr(1, 8'h00);
    // R4: mask and masked requests
    tag = "R4"; wr(1, 8'hF0); rd(1);
    req = 8'h90; cycle(); check("masked lines idle", int'(int_o), 0);
    req = 8'h05; cycle();
    // R8 / R7: acknowledge and nesting
    tag = "R8"; ack(); check("first vector", int'(ack_vec), 'h40);
    tag = "R7"; cycle(); ack();
    // R5: read select
    tag = "R5"; wr(0, 8'h0B); rd(0); wr(0, 8'h0A); rd(0);
    // R10: non-specific clear
    tag = "R10"; wr(0, 8'h20); cycle(); ack(); req = 8'h0A; wr(0, 8'h20); ack();
    // R11: specific clear and rotate
    tag = "R11"; wr(0, 8'h63); wr(0, 8'hE1); rd(0);
    req = 8'h0F; ack(); ack();
    // R12: priority set, no-op
    tag = "R12"; wr(0, 8'h40); wr(0, 8'hC4); wr(0, 8'h20); wr(0, 8'h20); ack();
    tag = "R10"; wr(0, 8'hA0); ack(); wr(0, 8'hA0);
    // R6: poll
    tag = "R6"; req = 8'h0C; wr(0, 8'h0C); rd(0); wr(0, 8'h0C); rd(1);
    req = 8'h00; wr(0, 8'h0C); rd(0); check("empty poll", int'(rd_data), 0);
    tag = "R8"; ack();
    // R9: auto-clear with rotation, single init skips cascade byte
    tag = "R9"; wr(0, 8'h13); wr(1, 8'h88); wr(1, 8'h02);
    wr(0, 8'h80); req = 8'h21; ack(); ack(); ack();
    wr(0, 8'h00); req = 8'h44; ack(); ack();
    // R2: single init without mode byte; next byte is mask
    tag = "R2"; wr(0, 8'h12); wr(1, 8'h30); wr(1, 8'h01); rd(1);
    req = 8'h03; ack();
    // R13: special nesting and special mask
    tag = "R13"; wr(0, 8'h11); wr(1, 8'h08); wr(1, 8'h00); wr(1, 8'h10);
    wr(1, 8'h00); req = 8'h04; ack(); req = 8'h20; cycle();
    check("nesting ignores cascade line", int'(int_o), 1);
    wr(0, 8'h62); req = 8'h08; ack(); req = 8'h40; cycle();
    wr(1, 8'h08); wr(0, 8'h28); cycle(); wr(0, 8'h08); cycle();
    ack(); ack();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule